// File: doc/BRIEF.md
# Programmable Raster Timing Generator

This block produces the timing skeleton of a video raster: a pixel counter and a line counter, horizontal and vertical blanking, horizontal and vertical sync, an active-video flag, a field indicator and a start-of-raster strobe. Every timing value sits in a shadow register written through a simple word-addressed configuration port. The shadow set reaches the counters and decoders only after software writes the commit bit, and then only at the first pixel of the following raster, so a raster never mixes two timing sets.

The raster can be progressive or interlaced with two fields. Each field has its own vertical blanking window and its own vertical sync window. A vertical sync window starts and ends at a pixel position inside a line, not only at a line boundary. A value of all ones in the field-2 first-line field marks the raster as progressive, and the block then ignores every field-2 window. A mode bit steers the two timing outputs so that they carry either the sync pulses or the blanking windows. A 16-bit counter records how many rasters have been produced.

Two small state machines drive the block. The commit machine has the states CM_IDLE and CM_ARMED. A commit write moves it from CM_IDLE to CM_ARMED. At the end of a raster, with no new commit in the same cycle, it returns from CM_ARMED to CM_IDLE and copies the shadow set into the active set. In every other cycle it holds its state. The field machine has the states FLD_ONE and FLD_TWO. At the end of a line it goes from FLD_ONE to FLD_TWO when the next line is the first line of field 2. It goes from FLD_TWO back to FLD_ONE when the next line is the first line of field 1.

Top module: `raster_timing_gen`

## Requirements
- R1: After reset the pixel and line counters are 0, the field output is 0, the commit-pending bit reads 0, the frame count reads 0, and the shadow and active sets both hold a 16-pixel by 8-line progressive raster. That raster has first active pixel 4, horizontal sync over pixels 1 to 2, vertical blanking from line 6 to first active line 1, vertical sync from (line 6, pixel 2) to (line 7, pixel 2), field-1 first line 0, all field-2 values 0xFFFF, and mode 0. Reading word 2 therefore returns 0x0008_0010.
- R2: The pixel counter runs from 0 to total width - 1. The line counter advances by one when the pixel counter wraps and runs from 0 to total height - 1. The start-of-raster output is 1 exactly when both counters are 0.
- R3: Shadow writes do not change any output. Writing 1 to bit 0 of word 0 makes bit 0 of word 0 read 1 from the next cycle. That bit stays 1 until the last pixel of the current raster, and at that point the shadow set becomes active from pixel 0 of line 0 onward.
- R4: Word 2 holds the total width in bits 15:0 and the total height in bits 31:16.
- R5: A pixel is horizontally blanked when its position is below the value in word 3, bits 15:0, which gives the first active pixel. The active output is 1 only when the pixel is neither horizontally nor vertically blanked.
- R6: Horizontal sync is asserted from the start pixel (word 4, bits 15:0) up to but excluding the end pixel (word 4, bits 31:16). When the end is below the start, the window wraps past the end of the line.
- R7: Vertical blanking for field 1 covers the lines from word 5 bits 15:0 up to but excluding the first active line in bits 31:16, wrapping when the end is below the start. Word 6 does the same for field 2, in the same layout.
- R8: Vertical sync for field 1 is asserted from (line in word 8 bits 31:16, pixel in bits 15:0) up to but excluding (line in word 9 bits 31:16, pixel in bits 15:0). Words 10 and 11 describe field 2 in the same layout.
- R9: When the field-2 first line (word 7, bits 31:16) is 0xFFFF, the raster is progressive: field-2 blanking and sync windows have no effect and the field output never switches to field 2.
- R10: The field output changes at the start of a line. It becomes 1 on the line equal to the field-2 first line and returns to 0 on the line equal to the field-1 first line (word 7, bits 15:0).
- R11: With mode bit 0 of word 1 at 0, the horizontal and vertical timing outputs carry the sync windows. With it at 1, they carry the horizontal and vertical blanking windows.
- R12: Word 12 returns in bits 31:16 a count of completed rasters, which increases by one after each last pixel of a raster and wraps modulo 65536.
- R13: Words 1 to 11 read back the shadow values last written, with unused bits as 0. Words 13 to 15 read as 0 and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | ADDR_BITS | Configuration word address |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rdata | output | 32 | Configuration read data for cfg_addr |
| h_cnt_o | output | H_BITS | Pixel position in the line |
| v_cnt_o | output | V_BITS | Line position in the raster |
| h_sig_o | output | 1 | Horizontal sync or blanking, chosen by mode |
| v_sig_o | output | 1 | Vertical sync or blanking, chosen by mode |
| active_o | output | 1 | Pixel lies in the active picture |
| field_o | output | 1 | 0 in field 1, 1 in field 2 |
| sof_o | output | 1 | First pixel of the raster |

## Verification
The bench builds the block with H_BITS = 7 and V_BITS = 6. These widths are large enough for 20-pixel lines and rasters of up to 12 lines, while keeping every raster under 250 cycles. Within that budget the bench can run several complete rasters for each timing set. It covers a wrapping horizontal sync, wrapping field-2 blanking, sub-line vertical sync edges in both fields, and a change from interlaced back to progressive, where the field output must fall back to 0.

// File: rtl/rtg_pkg.sv
package rtg_pkg;

    typedef struct packed {
        logic [15:0] ht;     logic [15:0] vt;     logic [15:0] hbe;
        logic [15:0] hss;    logic [15:0] hse;
        logic [15:0] vb1s;   logic [15:0] vb1e;   logic [15:0] vb2s;   logic [15:0] vb2e;
        logic [15:0] f1l;    logic [15:0] f2l;
        logic [15:0] vs1ps;  logic [15:0] vs1ls;  logic [15:0] vs1pe;  logic [15:0] vs1le;
        logic [15:0] vs2ps;  logic [15:0] vs2ls;  logic [15:0] vs2pe;  logic [15:0] vs2le;
        logic        blank_sel;
    } rtg_cfg_t;

    localparam logic [15:0] RTG_NONE = 16'hFFFF;

    localparam rtg_cfg_t RTG_CFG_RESET = '{
        ht: 16'd16, vt: 16'd8, hbe: 16'd4, hss: 16'd1, hse: 16'd3,
        vb1s: 16'd6, vb1e: 16'd1, vb2s: RTG_NONE, vb2e: RTG_NONE,
        f1l: 16'd0, f2l: RTG_NONE,
        vs1ps: 16'd2, vs1ls: 16'd6, vs1pe: 16'd2, vs1le: 16'd7,
        vs2ps: RTG_NONE, vs2ls: RTG_NONE, vs2pe: RTG_NONE, vs2le: RTG_NONE,
        blank_sel: 1'b0
    };

    localparam int RA_COMMIT = 0;
    localparam int RA_MODE   = 1;
    localparam int RA_TOTALS = 2;
    localparam int RA_HBEND  = 3;
    localparam int RA_HSYNC  = 4;
    localparam int RA_VBF1   = 5;
    localparam int RA_VBF2   = 6;
    localparam int RA_FIELDS = 7;
    localparam int RA_VS1ON  = 8;
    localparam int RA_VS1OFF = 9;
    localparam int RA_VS2ON  = 10;
    localparam int RA_VS2OFF = 11;
    localparam int RA_FRAMES = 12;

    typedef enum logic { CM_IDLE, CM_ARMED } rtg_commit_e;
    typedef enum logic { FLD_ONE, FLD_TWO } rtg_field_e;

    function automatic logic in_span(input logic [15:0] x, input logic [15:0] s,
                                     input logic [15:0] e);
        return (s <= e) ? (x >= s && x < e) : (x >= s || x < e);
    endfunction

    function automatic logic in_window(input logic [15:0] v, input logic [15:0] h,
                                       input logic [15:0] ls, input logic [15:0] ps,
                                       input logic [15:0] le, input logic [15:0] pe);
        logic started, not_ended;
        started   = (v > ls) || (v == ls && h >= ps);
        not_ended = (v < le) || (v == le && h < pe);
        return started && not_ended;
    endfunction

endpackage

// File: rtl/rtg_cfg_bank.sv
module rtg_cfg_bank
    import rtg_pkg::*;
#(
    parameter int ADDR_BITS = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cfg_we,
    input  logic [ADDR_BITS-1:0] cfg_addr,
    input  logic [31:0]          cfg_wdata,
    input  logic                 raster_end,
    input  logic [15:0]          frame_cnt,
    output rtg_cfg_t             act_cfg,
    output rtg_cfg_t             nxt_cfg,
    output logic [31:0]          cfg_rdata
);

    rtg_cfg_t    shd_cfg;
    rtg_commit_e state, state_nx;
    logic        commit_wr, load, pending;
    logic [15:0] lo, hi;

    assign lo        = cfg_wdata[15:0];
    assign hi        = cfg_wdata[31:16];
    assign commit_wr = cfg_we && (int'(cfg_addr) == RA_COMMIT) && cfg_wdata[0];

    always_comb begin
        state_nx = state;
        unique case (state)
            CM_IDLE:  if (commit_wr) state_nx = CM_ARMED;
            CM_ARMED: if (raster_end && !commit_wr) state_nx = CM_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= CM_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        pending = (state == CM_ARMED);
        load    = pending && raster_end;
        nxt_cfg = load ? shd_cfg : act_cfg;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shd_cfg <= RTG_CFG_RESET;
            act_cfg <= RTG_CFG_RESET;
        end else begin
            if (load) act_cfg <= shd_cfg;
            if (cfg_we) begin
                case (int'(cfg_addr))
                    RA_MODE:   shd_cfg.blank_sel <= cfg_wdata[0];
                    RA_TOTALS: begin shd_cfg.ht    <= lo; shd_cfg.vt    <= hi; end
                    RA_HBEND:  shd_cfg.hbe <= lo;
                    RA_HSYNC:  begin shd_cfg.hss   <= lo; shd_cfg.hse   <= hi; end
                    RA_VBF1:   begin shd_cfg.vb1s  <= lo; shd_cfg.vb1e  <= hi; end
                    RA_VBF2:   begin shd_cfg.vb2s  <= lo; shd_cfg.vb2e  <= hi; end
                    RA_FIELDS: begin shd_cfg.f1l   <= lo; shd_cfg.f2l   <= hi; end
                    RA_VS1ON:  begin shd_cfg.vs1ps <= lo; shd_cfg.vs1ls <= hi; end
                    RA_VS1OFF: begin shd_cfg.vs1pe <= lo; shd_cfg.vs1le <= hi; end
                    RA_VS2ON:  begin shd_cfg.vs2ps <= lo; shd_cfg.vs2ls <= hi; end
                    RA_VS2OFF: begin shd_cfg.vs2pe <= lo; shd_cfg.vs2le <= hi; end
                    default: ;
                endcase
            end
        end
    end

    always_comb begin
        case (int'(cfg_addr))
            RA_COMMIT: cfg_rdata = {31'd0, pending};
            RA_MODE:   cfg_rdata = {31'd0, shd_cfg.blank_sel};
            RA_TOTALS: cfg_rdata = {shd_cfg.vt, shd_cfg.ht};
            RA_HBEND:  cfg_rdata = {16'd0, shd_cfg.hbe};
            RA_HSYNC:  cfg_rdata = {shd_cfg.hse, shd_cfg.hss};
            RA_VBF1:   cfg_rdata = {shd_cfg.vb1e, shd_cfg.vb1s};
            RA_VBF2:   cfg_rdata = {shd_cfg.vb2e, shd_cfg.vb2s};
            RA_FIELDS: cfg_rdata = {shd_cfg.f2l, shd_cfg.f1l};
            RA_VS1ON:  cfg_rdata = {shd_cfg.vs1ls, shd_cfg.vs1ps};
            RA_VS1OFF: cfg_rdata = {shd_cfg.vs1le, shd_cfg.vs1pe};
            RA_VS2ON:  cfg_rdata = {shd_cfg.vs2ls, shd_cfg.vs2ps};
            RA_VS2OFF: cfg_rdata = {shd_cfg.vs2le, shd_cfg.vs2pe};
            RA_FRAMES: cfg_rdata = {frame_cnt, 16'd0};
            default:   cfg_rdata = 32'd0;
        endcase
    end

    AST_PEND_SET: assert property (@(posedge clk) disable iff (!rst_n)
        commit_wr |=> pending);                                            // R3
    AST_ACTIVE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !raster_end |=> $stable(act_cfg));                                 // R3
    AST_ACTIVE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (pending && raster_end) |=> (act_cfg == $past(shd_cfg)));          // R3

endmodule

// File: rtl/rtg_raster_cnt.sv
module rtg_raster_cnt
    import rtg_pkg::*;
#(
    parameter int H_BITS = 12,
    parameter int V_BITS = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  rtg_cfg_t          act_cfg,
    input  rtg_cfg_t          nxt_cfg,
    output logic [H_BITS-1:0] h_cnt,
    output logic [V_BITS-1:0] v_cnt,
    output logic              raster_end,
    output logic              field,
    output logic [15:0]       frame_cnt
);

    rtg_field_e  fld, fld_nx;
    logic        h_last, v_last;
    logic [15:0] next_line;

    always_comb begin
        h_last     = (16'(h_cnt) == act_cfg.ht - 16'd1);
        v_last     = (16'(v_cnt) == act_cfg.vt - 16'd1);
        raster_end = h_last && v_last;
        next_line  = v_last ? 16'd0 : 16'(v_cnt) + 16'd1;
    end

    always_comb begin
        fld_nx = fld;
        if (h_last) begin
            unique case (fld)
                FLD_ONE: if (next_line == nxt_cfg.f2l) fld_nx = FLD_TWO;
                FLD_TWO: if (next_line == nxt_cfg.f1l) fld_nx = FLD_ONE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) fld <= FLD_ONE;
        else        fld <= fld_nx;
    end

    assign field = (fld == FLD_TWO);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            h_cnt     <= '0;
            v_cnt     <= '0;
            frame_cnt <= '0;
        end else if (h_last) begin
            h_cnt <= '0;
            v_cnt <= v_last ? '0 : v_cnt + 1'b1;
            if (v_last) frame_cnt <= frame_cnt + 16'd1;
        end else begin
            h_cnt <= h_cnt + 1'b1;
        end
    end

    AST_H_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        16'(h_cnt) < act_cfg.ht);                                          // R2
    AST_LINE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (h_last && !v_last) |=> (v_cnt == $past(v_cnt) + 1'b1 && h_cnt == '0)); // R2
    AST_RASTER_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        raster_end |=> (h_cnt == '0 && v_cnt == '0));                      // R2
    AST_FRAME_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        raster_end |=> (frame_cnt == $past(frame_cnt) + 16'd1));           // R12
    AST_FIELD_MIDLINE: assert property (@(posedge clk) disable iff (!rst_n)
        !h_last |=> $stable(field));                                       // R10

endmodule

// File: rtl/rtg_sync_decode.sv
module rtg_sync_decode
    import rtg_pkg::*;
#(
    parameter int H_BITS = 12,
    parameter int V_BITS = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  rtg_cfg_t          act_cfg,
    input  logic [H_BITS-1:0] h_cnt,
    input  logic [V_BITS-1:0] v_cnt,
    output logic              h_sig,
    output logic              v_sig,
    output logic              active,
    output logic              sof
);

    logic [15:0] h, v;
    logic        interlaced, hblank, vblank, hsync, vsync;

    always_comb begin
        h          = 16'(h_cnt);
        v          = 16'(v_cnt);
        interlaced = (act_cfg.f2l != RTG_NONE);
        hblank     = (h < act_cfg.hbe);
        hsync      = in_span(h, act_cfg.hss, act_cfg.hse);
        vblank     = in_span(v, act_cfg.vb1s, act_cfg.vb1e)
                   || (interlaced && in_span(v, act_cfg.vb2s, act_cfg.vb2e));
        vsync      = in_window(v, h, act_cfg.vs1ls, act_cfg.vs1ps, act_cfg.vs1le, act_cfg.vs1pe)
                   || (interlaced && in_window(v, h, act_cfg.vs2ls, act_cfg.vs2ps,
                                                     act_cfg.vs2le, act_cfg.vs2pe));
        h_sig      = act_cfg.blank_sel ? hblank : hsync;
        v_sig      = act_cfg.blank_sel ? vblank : vsync;
        active     = !hblank && !vblank;
        sof        = (h == 16'd0) && (v == 16'd0);
    end

    AST_BLANK_VS_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
        (act_cfg.blank_sel && active) |-> (!h_sig && !v_sig));            // R11
    AST_SOF_HBLANK: assert property (@(posedge clk) disable iff (!rst_n)
        (sof && act_cfg.hbe != 16'd0) |-> !active);                        // R5

endmodule

// File: rtl/raster_timing_gen.sv
module raster_timing_gen
    import rtg_pkg::*;
#(
    parameter int H_BITS    = 12,
    parameter int V_BITS    = 11,
    parameter int ADDR_BITS = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cfg_we,
    input  logic [ADDR_BITS-1:0] cfg_addr,
    input  logic [31:0]          cfg_wdata,
    output logic [31:0]          cfg_rdata,
    output logic [H_BITS-1:0]    h_cnt_o,
    output logic [V_BITS-1:0]    v_cnt_o,
    output logic                 h_sig_o,
    output logic                 v_sig_o,
    output logic                 active_o,
    output logic                 field_o,
    output logic                 sof_o
);

    rtg_cfg_t    act_cfg, nxt_cfg;
    logic        raster_end;
    logic [15:0] frame_cnt;

    rtg_cfg_bank #(.ADDR_BITS(ADDR_BITS)) u_bank (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .raster_end(raster_end), .frame_cnt(frame_cnt),
        .act_cfg(act_cfg), .nxt_cfg(nxt_cfg), .cfg_rdata(cfg_rdata)
    );

    rtg_raster_cnt #(.H_BITS(H_BITS), .V_BITS(V_BITS)) u_cnt (
        .clk(clk), .rst_n(rst_n), .act_cfg(act_cfg), .nxt_cfg(nxt_cfg),
        .h_cnt(h_cnt_o), .v_cnt(v_cnt_o), .raster_end(raster_end),
        .field(field_o), .frame_cnt(frame_cnt)
    );

    rtg_sync_decode #(.H_BITS(H_BITS), .V_BITS(V_BITS)) u_dec (
        .clk(clk), .rst_n(rst_n), .act_cfg(act_cfg), .h_cnt(h_cnt_o), .v_cnt(v_cnt_o),
        .h_sig(h_sig_o), .v_sig(v_sig_o), .active(active_o), .sof(sof_o)
    );

endmodule

// File: tb/raster_timing_gen_tb_top.sv
module raster_timing_gen_tb_top;

    localparam int HB = 7;
    localparam int VB = 6;
    localparam int AB = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_we = 1'b0;
    logic [AB-1:0] cfg_addr = '0;
    logic [31:0]   cfg_wdata = '0;
    logic [31:0]   cfg_rdata;
    logic [HB-1:0] h_cnt_o;
    logic [VB-1:0] v_cnt_o;
    logic          h_sig_o, v_sig_o, active_o, field_o, sof_o;

    always #10 clk = ~clk;

    raster_timing_gen #(.H_BITS(HB), .V_BITS(VB), .ADDR_BITS(AB)) dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .h_cnt_o(h_cnt_o),
        .v_cnt_o(v_cnt_o), .h_sig_o(h_sig_o), .v_sig_o(v_sig_o),
        .active_o(active_o), .field_o(field_o), .sof_o(sof_o)
    );

    // model state: A = active set, S = shadow set (index order of the bench only)
    int A[20];
    int S[20];
    int hc, vc, fld, frames, pend;
    int n_cmp = 0, n_bad = 0;
    bit run = 1'b0, done = 1'b0;

    task automatic defaults();
        int d[20] = '{16, 8, 4, 1, 3, 6, 1, 65535, 65535, 0, 65535,
                      2, 6, 2, 7, 65535, 65535, 65535, 65535, 0};
        for (int i = 0; i < 20; i++) begin A[i] = d[i]; S[i] = d[i]; end
    endtask

    function automatic bit span(int x, int s, int e);
        return (s <= e) ? (x >= s && x < e) : (x >= s || x < e);
    endfunction

    function automatic bit win(int v, int h, int ls, int ps, int le, int pe);
        return ((v > ls) || (v == ls && h >= ps)) && ((v < le) || (v == le && h < pe));
    endfunction

    task automatic check(string tag, int got, int exp);
        n_cmp++;
        if (got != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, got, exp, $time);
        end
    endtask

    // behavioural reference, advanced on every rising edge
    always @(posedge clk) begin
        if (!rst_n) begin
            defaults();
            hc = 0; vc = 0; fld = 0; frames = 0; pend = 0;
        end else begin
            int lo, hi, nl, p[20];
            bit hl, vl, wrap, ld, cw;
            lo = int'(cfg_wdata[15:0]);
            hi = int'(cfg_wdata[31:16]);
            hl = (hc == A[0] - 1);
            vl = (vc == A[1] - 1);
            wrap = hl && vl;
            ld = (pend != 0) && wrap;
            cw = cfg_we && cfg_addr == 0 && cfg_wdata[0];
            if (hl) begin
                nl = vl ? 0 : vc + 1;
                p = ld ? S : A;
                if (fld == 0 && nl == p[10]) fld = 1;
                else if (fld == 1 && nl == p[9]) fld = 0;
            end
            if (ld) A = S;
            if (hl) begin hc = 0; vc = vl ? 0 : vc + 1; end
            else hc = hc + 1;
            if (wrap) frames = (frames + 1) % 65536;
            pend = cw ? 1 : (wrap ? 0 : pend);
            if (cfg_we) begin
                case (int'(cfg_addr))
                    1:  S[19] = int'(cfg_wdata[0]);
                    2:  begin S[0] = lo;  S[1] = hi;  end
                    3:  S[2] = lo;
                    4:  begin S[3] = lo;  S[4] = hi;  end
                    5:  begin S[5] = lo;  S[6] = hi;  end
                    6:  begin S[7] = lo;  S[8] = hi;  end
                    7:  begin S[9] = lo;  S[10] = hi; end
                    8:  begin S[11] = lo; S[12] = hi; end
                    9:  begin S[13] = lo; S[14] = hi; end
                    10: begin S[15] = lo; S[16] = hi; end
                    11: begin S[17] = lo; S[18] = hi; end
                    default: ;
                endcase
            end
        end
    end

    // compare every cycle away from the active edge
    always @(negedge clk) begin
        if (rst_n && run) begin
            bit hbl, hs, il, vbl, vs;
            hbl = hc < A[2];
            hs  = span(hc, A[3], A[4]);
            il  = (A[10] != 65535);
            vbl = span(vc, A[5], A[6]) || (il && span(vc, A[7], A[8]));
            vs  = win(vc, hc, A[12], A[11], A[14], A[13])
               || (il && win(vc, hc, A[16], A[15], A[18], A[17]));
            check("R2 h_cnt", int'(h_cnt_o), hc);
            check("R2 v_cnt", int'(v_cnt_o), vc);
            check("R2 sof", int'(sof_o), int'(hc == 0 && vc == 0));
            check("R11/R6 h_sig", int'(h_sig_o), int'(A[19] != 0 ? hbl : hs));
            check("R11/R8/R7 v_sig", int'(v_sig_o), int'(A[19] != 0 ? vbl : vs));
            check("R5/R7 active", int'(active_o), int'(!hbl && !vbl));
            check("R10/R9 field", int'(field_o), fld);
        end
    end

    function automatic int exp_rd(int a);
        case (a)
            0: return pend;
            1: return S[19];
            2: return (S[1] << 16) | S[0];
            3: return S[2];
            4: return (S[4] << 16) | S[3];
            5: return (S[6] << 16) | S[5];
            6: return (S[8] << 16) | S[7];
            7: return (S[10] << 16) | S[9];
            8: return (S[12] << 16) | S[11];
            9: return (S[14] << 16) | S[13];
            10: return (S[16] << 16) | S[15];
            11: return (S[18] << 16) | S[17];
            12: return frames << 16;
            default: return 0;
        endcase
    endfunction

    task automatic wr(int a, int hi, int lo);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = AB'(a); cfg_wdata = {hi[15:0], lo[15:0]};
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic rd(string tag, int a, int exp);
        cfg_addr = AB'(a);
        #1;
        check(tag, int'(cfg_rdata), exp);
    endtask

    task automatic commit_and_wait();
        wr(0, 0, 1);
        rd("R3 pending set", 0, 1);
        while (pend != 0) @(negedge clk);
        #2;
        rd("R3 pending clear", 0, 0);
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    initial begin
        #(20 * 100000);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL R2 watchdog actual=running expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 h_cnt in reset", int'(h_cnt_o), 0);
        check("R1 field in reset", int'(field_o), 0);
        rst_n = 1'b1;
        run = 1'b1;
        #1;
        rd("R1 totals reset", 2, 32'h0008_0010);
        rd("R1 pending reset", 0, 0);
        rd("R1 frames reset", 12, 0);
        rd("R1 sync window reset", 8, 32'h0006_0002);
        repeat (300) @(negedge clk);
        rd("R12 frame count", 12, exp_rd(12));

        // progressive 20x10, wrapping horizontal sync, sync mode
        wr(2, 10, 20);
        wr(3, 0, 5);
        wr(4, 2, 18);
        wr(5, 1, 8);
        wr(8, 8, 3);
        wr(9, 9, 3);
        wr(13, 16'h1234, 16'h5678);
        #2;
        rd("R4 totals readback", 2, 32'h000A_0014);
        rd("R6 hsync readback", 4, exp_rd(4));
        rd("R13 unused word", 13, 0);
        repeat (40) @(negedge clk);   // shadow only: per-cycle compare covers R3
        commit_and_wait();
        repeat (400) @(negedge clk);

        // blanking on the timing outputs
        wr(1, 0, 1);
        #2;
        rd("R11 mode readback", 1, 1);
        commit_and_wait();
        repeat (400) @(negedge clk);

        // interlaced raster, 12 lines, field 2 from line 6
        wr(2, 12, 20);
        wr(7, 6, 0);
        wr(5, 7, 5);
        wr(6, 1, 11);
        wr(8, 5, 3);
        wr(9, 6, 8);
        wr(10, 10, 10);
        wr(11, 11, 4);
        wr(1, 0, 0);
        #2;
        rd("R13 fields readback", 7, 32'h0006_0000);
        commit_and_wait();
        repeat (600) @(negedge clk);
        wr(1, 0, 1);
        commit_and_wait();
        repeat (300) @(negedge clk);

        // back to progressive: field 2 windows ignored, field returns to 0
        wr(7, 16'hFFFF, 0);
        wr(1, 0, 0);
        commit_and_wait();
        repeat (300) @(negedge clk);
        check("R9 field after progressive", int'(field_o), 0);
        rd("R12 frame count end", 12, exp_rd(12));
        rd("R13 vs2 readback", 11, exp_rd(11));

        done = 1'b1;
        summary();
        $finish;
    end

endmodule